// File: doc/BRIEF.md
# Sticky-Bit Configuration Register Bank

This block is a bank of eleven 32-bit configuration registers reached over a simple synchronous bus. The bus has an address, a read strobe, a write strobe and write data, and it returns registered read data and an error flag. Each register applies its own write rule. Some bits are plain masked storage. Some can only be cleared by software. Some can only be set by software and are cleared only by reset. One is a flag that software clears by writing a one.

The block holds state only. Every register value is driven out continuously so that the surrounding logic can use it. A single hardware input, pulsed for one cycle, raises the memory parity flag. The decoded window is 1 KiB, and only full-word, word-aligned accesses are valid.

Top module: `cfg_sticky_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except config 1, which reads 0x7C000001.
- R2: The remap register (offset 0x00) stores only the written bits selected by mask 0x00000107.
- R3: Config 1 (offset 0x04) stores the written bits selected by mask 0xFCFF0100. A write replaces those bits.
- R4: Config 1 bit 0 can be cleared by software but never set by software: its new value is the old bit 0 AND the written bit 0. Only reset sets it again.
- R5: Four line-select registers sit at offsets 0x08, 0x0C, 0x10 and 0x14. Each stores the low 16 bits of a write. On the line_sel_o bus, register k occupies bits [16k+15:16k].
- R6: Config 2 (offset 0x1C) bits [3:0] are set-only: a write ORs in the written bits, and only reset clears them.
- R7: Config 2 bit 8 is raised by a one-cycle pulse on hw_parity_set. Software clears it by writing 1 to bit 8, and writing 0 to bit 8 leaves it unchanged. If a set pulse and a clearing write fall in the same cycle, the flag ends up set.
- R8: Protect 1 (offset 0x20) and protect 2 (offset 0x28) OR in every written bit and are cleared only by reset. The key register (offset 0x24) stores the low 8 bits of a write.
- R9: The status/control register at offset 0x18 ignores writes, reads zero, and raises no error.
- R10: An access to an offset at or above 0x2C, or to a non-word-aligned address, changes no register, returns read data zero, and sets bus_err in the following cycle.
- R11: Read data and bus_err are registered and valid one cycle after the request. In a cycle that follows no read, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Byte address within the window |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered access error |
| hw_parity_set | input | 1 | One-cycle pulse that raises the parity flag |
| remap_o | output | 32 | Remap register value |
| cfg1_o | output | 32 | Config 1 value |
| line_sel_o | output | 64 | Four 16-bit line-select values, packed |
| cfg2_o | output | 32 | Config 2 value |
| prot1_o | output | 32 | Protect 1 value |
| key_o | output | 32 | Key register value |
| prot2_o | output | 32 | Protect 2 value |

## Verification
The bench writes all ones to config 1 after reset and checks that bit 0 survives exactly once and can never come back after a write of zero. A design that treated bit 0 as plain storage would read back 1 after the final write.

It ORs disjoint patterns into the set-only fields and then writes zero. A plain register would lose the earlier bits.

It fires the parity pulse in the same cycle as a write-one-to-clear. If the clear were given priority, the flag would read zero.

Unaligned and out-of-window writes are followed by reads of the register they would otherwise alias. A decoder that dropped the alignment check or the upper-offset check would corrupt that register or fail to raise the error.

// File: rtl/cfg_sticky_pkg.sv
// Package: constants shared by the sticky configuration register bank.
// Assumes 32-bit data and word offsets counted from the base of the window.
package cfg_sticky_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 10;
    localparam int LSEL_W   = 16;
    localparam int NUM_LSEL = 4;
    localparam int NUM_REGS = 11;

    // Word indices (byte offset / 4).
    localparam int IDX_REMAP = 0;
    localparam int IDX_CFG1  = 1;
    localparam int IDX_LSEL0 = 2;
    localparam int IDX_STAT  = 6;
    localparam int IDX_CFG2  = 7;
    localparam int IDX_PROT1 = 8;
    localparam int IDX_KEY   = 9;
    localparam int IDX_PROT2 = 10;

    localparam logic [DATA_W-1:0] M_NONE      = 32'h0000_0000;
    localparam logic [DATA_W-1:0] M_REMAP     = 32'h0000_0107;
    localparam logic [DATA_W-1:0] M_CFG1      = 32'hFCFF_0100;
    localparam logic [DATA_W-1:0] M_CFG1_CLR  = 32'h0000_0001;
    localparam logic [DATA_W-1:0] RST_CFG1    = 32'h7C00_0001;
    localparam logic [DATA_W-1:0] M_LSEL      = 32'h0000_FFFF;
    localparam logic [DATA_W-1:0] M_CFG2_LOCK = 32'h0000_000F;
    localparam logic [DATA_W-1:0] M_CFG2_FLAG = 32'h0000_0100;
    localparam logic [DATA_W-1:0] M_KEY       = 32'h0000_00FF;
    localparam logic [DATA_W-1:0] M_ALL       = 32'hFFFF_FFFF;
endpackage

// File: rtl/cfg_addr_decode.sv
// Module: address decoder for the register bank.
// Produces a one-hot register select and a hit flag. Only word-aligned
// addresses whose word index is below NUM_REGS hit.
module cfg_addr_decode #(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 11
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_REGS);

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    // Hit when aligned and inside the populated range.
    always_comb begin
        hit = (addr[1:0] == 2'b00) && (idx < LIMIT);
    end

    // One select line per register, gated by hit.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            sel[i] = hit && (idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/cfg_sticky_field.sv
// Module: one 32-bit register with per-bit write rules.
// The masks must be disjoint. On a write:
//   PLAIN_M bits take the written value;
//   CLR_M bits become old AND written;
//   SET_M bits become old OR written;
//   W1C_M bits clear where a 1 is written.
// A hw_set pulse then ORs in HWSET_M, so a hardware set beats a software
// clear in the same cycle. Bits outside every mask stay zero.
module cfg_sticky_field #(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] PLAIN_M = '0,
    parameter logic [DATA_W-1:0] CLR_M   = '0,
    parameter logic [DATA_W-1:0] SET_M   = '0,
    parameter logic [DATA_W-1:0] W1C_M   = '0,
    parameter logic [DATA_W-1:0] HWSET_M = '0,
    parameter logic [DATA_W-1:0] RST_V   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_set,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    // Next value from the write rules, then the hardware set.
    always_comb begin
        nxt = q;
        if (we) begin
            nxt = (wdata & PLAIN_M)
                | (q & wdata & CLR_M)
                | ((q | wdata) & SET_M)
                | (q & ~wdata & W1C_M);
        end
        if (hw_set) begin
            nxt = nxt | HWSET_M;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_V;
        else        q <= nxt;
    end
endmodule

// File: rtl/cfg_sticky_regs.sv
// Module: top of the sticky configuration register bank.
// Decodes the bus, instantiates one field per register with its own rules,
// and returns registered read data and error one cycle after a request.
// Assumes at most one of read/write per register per cycle matters; a read
// in the same cycle as a write returns the old value.
module cfg_sticky_regs
    import cfg_sticky_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     bus_err,
    input  logic                     hw_parity_set,
    output logic [DATA_W-1:0]        remap_o,
    output logic [DATA_W-1:0]        cfg1_o,
    output logic [NUM_LSEL*LSEL_W-1:0] line_sel_o,
    output logic [DATA_W-1:0]        cfg2_o,
    output logic [DATA_W-1:0]        prot1_o,
    output logic [DATA_W-1:0]        key_o,
    output logic [DATA_W-1:0]        prot2_o
);
    logic [NUM_REGS-1:0] sel;
    logic                hit;
    logic [DATA_W-1:0]   rv [NUM_REGS];
    logic [DATA_W-1:0]   rd_val;

    cfg_addr_decode #(.ADDR_W(AW), .NUM_REGS(NUM_REGS)) u_dec (
        .addr(bus_addr), .sel(sel), .hit(hit)
    );

    cfg_sticky_field #(.DATA_W(DATA_W), .PLAIN_M(M_REMAP)) u_remap (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel[IDX_REMAP]),
        .wdata(bus_wdata), .hw_set(1'b0), .q(rv[IDX_REMAP])
    );

    cfg_sticky_field #(.DATA_W(DATA_W), .PLAIN_M(M_CFG1), .CLR_M(M_CFG1_CLR),
                       .RST_V(RST_CFG1)) u_cfg1 (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel[IDX_CFG1]),
        .wdata(bus_wdata), .hw_set(1'b0), .q(rv[IDX_CFG1])
    );

    // Line-select registers: identical plain 16-bit fields.
    for (genvar k = 0; k < NUM_LSEL; k++) begin : g_lsel
        cfg_sticky_field #(.DATA_W(DATA_W), .PLAIN_M(M_LSEL)) u_lsel (
            .clk(clk), .rst_n(rst_n), .we(bus_wr && sel[IDX_LSEL0+k]),
            .wdata(bus_wdata), .hw_set(1'b0), .q(rv[IDX_LSEL0+k])
        );
        assign line_sel_o[k*LSEL_W +: LSEL_W] = rv[IDX_LSEL0+k][LSEL_W-1:0];
    end

    // Status/control holds no state: writes ignored, reads zero.
    assign rv[IDX_STAT] = M_NONE;

    cfg_sticky_field #(.DATA_W(DATA_W), .SET_M(M_CFG2_LOCK), .W1C_M(M_CFG2_FLAG),
                       .HWSET_M(M_CFG2_FLAG)) u_cfg2 (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel[IDX_CFG2]),
        .wdata(bus_wdata), .hw_set(hw_parity_set), .q(rv[IDX_CFG2])
    );

    cfg_sticky_field #(.DATA_W(DATA_W), .SET_M(M_ALL)) u_prot1 (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel[IDX_PROT1]),
        .wdata(bus_wdata), .hw_set(1'b0), .q(rv[IDX_PROT1])
    );

    cfg_sticky_field #(.DATA_W(DATA_W), .PLAIN_M(M_KEY)) u_key (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel[IDX_KEY]),
        .wdata(bus_wdata), .hw_set(1'b0), .q(rv[IDX_KEY])
    );

    cfg_sticky_field #(.DATA_W(DATA_W), .SET_M(M_ALL)) u_prot2 (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && sel[IDX_PROT2]),
        .wdata(bus_wdata), .hw_set(1'b0), .q(rv[IDX_PROT2])
    );

    // Read multiplexer: OR of selected register (zero on a miss).
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) rd_val = rd_val | rv[i];
        end
    end

    // Registered response: data only after a read, error after a missed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_val : '0;
            bus_err   <= (bus_rd || bus_wr) && !hit;
        end
    end

    assign remap_o = rv[IDX_REMAP];
    assign cfg1_o  = rv[IDX_CFG1];
    assign cfg2_o  = rv[IDX_CFG2];
    assign prot1_o = rv[IDX_PROT1];
    assign key_o   = rv[IDX_KEY];
    assign prot2_o = rv[IDX_PROT2];
endmodule

// File: rtl/cfg_sticky_regs_chk.sv
// Module: assertion checker bound to cfg_sticky_regs.
// Observes only the ports of the top module.
module cfg_sticky_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic        hw_parity_set,
    input logic [31:0] cfg1_o,
    input logic [31:0] cfg2_o,
    input logic [31:0] prot1_o,
    input logic [31:0] prot2_o
);
    AST_CFG1_B0_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg1_o[0])) |-> !cfg1_o[0]); // R4

    AST_CFG2_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cfg2_o[3:0] & $past(cfg2_o[3:0])) == $past(cfg2_o[3:0]))); // R6

    AST_PARITY_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_parity_set |=> cfg2_o[8]); // R7

    AST_PROT1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((prot1_o & $past(prot1_o)) == $past(prot1_o))); // R8

    AST_PROT2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((prot2_o & $past(prot2_o)) == $past(prot2_o))); // R8

    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'h0)); // R10

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr)); // R10

    AST_RDATA_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != 32'h0) |-> $past(bus_rd)); // R11
endmodule

bind cfg_sticky_regs cfg_sticky_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .hw_parity_set(hw_parity_set),
    .cfg1_o(cfg1_o), .cfg2_o(cfg2_o), .prot1_o(prot1_o), .prot2_o(prot2_o)
);

// File: tb/cfg_sticky_regs_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module cfg_sticky_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        hw_parity_set = 1'b0;
    logic [31:0] remap_o, cfg1_o, cfg2_o, prot1_o, key_o, prot2_o;
    logic [63:0] line_sel_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_sticky_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .hw_parity_set(hw_parity_set), .remap_o(remap_o),
        .cfg1_o(cfg1_o), .line_sel_o(line_sel_o), .cfg2_o(cfg2_o),
        .prot1_o(prot1_o), .key_o(key_o), .prot2_o(prot2_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write: drive at negedge, captured at next posedge, error sampled at following negedge.
    task automatic wr(input logic [9:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        err = bus_err;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic err);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; err = bus_err;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        rd(10'h00, d, e); chk("R1 remap", d, 0);
        rd(10'h04, d, e); chk("R1 cfg1", d, 32'h7C00_0001);
        for (int i = 0; i < 4; i++) begin
            rd(10'(8 + 4*i), d, e); chk("R1 lsel", d, 0);
        end
        rd(10'h1C, d, e); chk("R1 cfg2", d, 0);
        rd(10'h20, d, e); chk("R1 prot1", d, 0);
        rd(10'h24, d, e); chk("R1 key", d, 0);
        rd(10'h28, d, e); chk("R1 prot2", d, 0);
        chk("R1 cfg1_o", cfg1_o, 32'h7C00_0001);
    endtask

    task automatic t_remap();
        logic [31:0] d; logic e;
        wr(10'h00, 32'hFFFF_FFFF, e);
        rd(10'h00, d, e); chk("R2 remap mask", d, 32'h0000_0107);
        chk("R2 remap_o", remap_o, 32'h0000_0107);
        wr(10'h00, 32'h0000_0102, e);
        rd(10'h00, d, e); chk("R2 remap partial", d, 32'h0000_0102);
    endtask

    task automatic t_cfg1();
        logic [31:0] d; logic e;
        wr(10'h04, 32'hFFFF_FFFF, e);
        rd(10'h04, d, e); chk("R3 cfg1 mask", d, 32'hFCFF_0101);
        wr(10'h04, 32'h0000_0000, e);
        rd(10'h04, d, e); chk("R4 cfg1 clear", d, 0);
        wr(10'h04, 32'hFFFF_FFFF, e);
        rd(10'h04, d, e); chk("R4 cfg1 b0 not set", d, 32'hFCFF_0100);
        do_reset();
        chk("R4 cfg1 b0 back after reset", cfg1_o, 32'h7C00_0001);
    endtask

    task automatic t_lsel();
        logic [31:0] d; logic e;
        for (int i = 0; i < 4; i++) wr(10'(8 + 4*i), 32'hA5A5_0000 | 32'(16'h1111 * (i + 1)), e);
        for (int i = 0; i < 4; i++) begin
            rd(10'(8 + 4*i), d, e); chk("R5 lsel read", d, 32'(16'h1111 * (i + 1)));
        end
        chk("R5 lsel packing", line_sel_o, 64'h4444_3333_2222_1111);
    endtask

    task automatic t_cfg2();
        logic [31:0] d; logic e;
        wr(10'h1C, 32'h0000_0005, e);
        wr(10'h1C, 32'h0000_000A, e);
        wr(10'h1C, 32'h0000_0000, e);
        rd(10'h1C, d, e); chk("R6 cfg2 lock OR", d, 32'h0000_000F);
        @(negedge clk); hw_parity_set = 1'b1;
        @(negedge clk); hw_parity_set = 1'b0;
        chk("R7 parity set", cfg2_o, 32'h0000_010F);
        wr(10'h1C, 32'h0000_0000, e);
        chk("R7 write 0 keeps flag", cfg2_o, 32'h0000_010F);
        wr(10'h1C, 32'h0000_0100, e);
        chk("R7 w1c clears", cfg2_o, 32'h0000_000F);
        @(negedge clk);
        bus_addr = 10'h1C; bus_wdata = 32'h0000_0100; bus_wr = 1'b1; hw_parity_set = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; hw_parity_set = 1'b0;
        chk("R7 set wins over clear", cfg2_o, 32'h0000_010F);
    endtask

    task automatic t_prot();
        logic [31:0] d; logic e;
        wr(10'h20, 32'h0000_00F0, e);
        wr(10'h20, 32'h0000_0F00, e);
        wr(10'h20, 32'h0000_0000, e);
        rd(10'h20, d, e); chk("R8 prot1 sticky", d, 32'h0000_0FF0);
        wr(10'h28, 32'h8000_0001, e);
        wr(10'h28, 32'h0000_0000, e);
        chk("R8 prot2 sticky", prot2_o, 32'h8000_0001);
        wr(10'h24, 32'hDEAD_BEEF, e);
        rd(10'h24, d, e); chk("R8 key low byte", d, 32'h0000_00EF);
    endtask

    task automatic t_status();
        logic [31:0] d; logic e;
        wr(10'h18, 32'hFFFF_FFFF, e); chk("R9 status write no err", e, 0);
        rd(10'h18, d, e); chk("R9 status reads zero", d, 0);
        chk("R9 status read no err", e, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        rd(10'h2C, d, e); chk("R10 unmapped read err", e, 1);
        chk("R10 unmapped read data", d, 0);
        wr(10'h3FC, 32'hFFFF_FFFF, e); chk("R10 unmapped write err", e, 1);
        rd(10'h02, d, e); chk("R10 unaligned read err", e, 1);
        chk("R10 unaligned read data", d, 0);
        wr(10'h01, 32'h0000_0001, e); chk("R10 unaligned write err", e, 1);
        rd(10'h00, d, e); chk("R10 remap untouched", d, 32'h0000_0102);
        chk("R10 mapped read no err", e, 0);
    endtask

    task automatic t_latency();
        logic [31:0] d; logic e;
        rd(10'h24, d, e); chk("R11 read data", d, 32'h0000_00EF);
        @(negedge clk);
        chk("R11 idle data zero", bus_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_remap();
        t_cfg1();
        t_remap();
        t_lsel();
        t_cfg2();
        t_prot();
        t_status();
        t_unmapped();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule